// File: doc/BRIEF.md
# SIMD Lane-Wise Logical Shifter

This unit takes a 256-bit operand and treats it as a row of equal-width unsigned lanes. Every lane is shifted by the same bit count. Lane 0 sits at the least significant end of the word. A two-bit width code picks the lane size at run time, and a direction bit picks a left or right shift. Each lane is shifted on its own. Bits pushed past a lane edge are dropped and never reach the lane next to it. Vacated positions fill with zeros.

The unit is purely combinational and sits inside a wider vector datapath. The result and the error flag follow the inputs in the same cycle. One width code has no meaning. For that code the unit raises an error flag and drives an all-zero result.

Top module: `simd_lane_shift`

## Requirements
- R1: Width code 0 (elen_i = 2'b00) selects 32-bit lanes, giving 8 lanes. Lane k is bits [32k+31:32k].
- R2: Width code 1 (elen_i = 2'b01) selects 64-bit lanes, giving 4 lanes. Lane k is bits [64k+63:64k].
- R3: Width code 2 (elen_i = 2'b10) selects 128-bit lanes, giving 2 lanes. Lane k is bits [128k+127:128k].
- R4: With dir_i = 0, each lane is shifted toward its most significant bit, and its lowest amt_i bits are filled with zero.
- R5: With dir_i = 1, each lane is shifted toward its least significant bit, and its highest amt_i bits are filled with zero.
- R6: No bit moves from one lane into another. The result of each lane depends only on the same lane of vec_i.
- R7: A shift amount equal to or greater than the lane width makes every lane zero.
- R8: A shift amount of zero returns vec_i unchanged for any legal width code.
- R9: Width code 3 (elen_i = 2'b11) sets err_o to 1 and drives res_o to all zeros, whatever the other inputs are.
- R10: For legal width codes err_o is 0. Both outputs follow the inputs combinationally, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vec_i | input | 256 | Operand vector |
| elen_i | input | 2 | Lane width code: 0 = 32, 1 = 64, 2 = 128, 3 = illegal |
| dir_i | input | 1 | 0 = shift left, 1 = shift right |
| amt_i | input | 8 | Shift amount in bits, unsigned |
| res_o | output | 256 | Lane-wise shifted result |
| err_o | output | 1 | High for the illegal width code |

## Verification
The bench builds the unit with its default parameters: a 256-bit word, a 32-bit base lane, three width codes and an 8-bit amount.

With an 8-bit amount, every value up to 255 can be driven. That covers amounts just below, at and far beyond each lane width, for all three widths and both directions. Every lane-edge discard case and every full-clear case is therefore reachable.

The default of three width codes inside a two-bit code field also leaves the one illegal code available, so the error path is exercised with live data on the operand.

// File: rtl/simd_shift_pkg.sv
package simd_shift_pkg;
    localparam int DATA_W     = 256;
    localparam int BASE_LANE  = 32;
    localparam int NUM_WIDTHS = 3;
    localparam int CODE_W     = 2;
    localparam int AMT_W      = 8;

    typedef enum logic {
        SHIFT_LEFT  = 1'b0,
        SHIFT_RIGHT = 1'b1
    } shift_dir_e;
endpackage

// File: rtl/simd_lane_unit.sv
module simd_lane_unit #(
    parameter int LANE_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [LANE_W-1:0] lane_i,
    input  logic              right_i,
    input  logic [AMT_W-1:0]  amt_i,
    output logic [LANE_W-1:0] lane_o
);
    // Amounts at or past the lane width clear the lane.
    logic too_far;
    assign too_far = (32'(amt_i) >= LANE_W);

    always_comb begin
        if (too_far) begin
            lane_o = '0;
        end else if (right_i) begin
            lane_o = lane_i >> amt_i;
        end else begin
            lane_o = lane_i << amt_i;
        end
    end
endmodule

// File: rtl/simd_width_stage.sv
module simd_width_stage #(
    parameter int DATA_W = 256,
    parameter int LANE_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [DATA_W-1:0] vec_i,
    input  logic              right_i,
    input  logic [AMT_W-1:0]  amt_i,
    output logic [DATA_W-1:0] vec_o
);
    localparam int LANES = DATA_W / LANE_W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        simd_lane_unit #(
            .LANE_W (LANE_W),
            .AMT_W  (AMT_W)
        ) u_lane (
            .lane_i  (vec_i[k*LANE_W +: LANE_W]),
            .right_i (right_i),
            .amt_i   (amt_i),
            .lane_o  (vec_o[k*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/simd_lane_shift.sv
module simd_lane_shift
    import simd_shift_pkg::*;
#(
    parameter int P_DATA_W     = DATA_W,
    parameter int P_BASE_LANE  = BASE_LANE,
    parameter int P_NUM_WIDTHS = NUM_WIDTHS,
    parameter int P_CODE_W     = CODE_W,
    parameter int P_AMT_W      = AMT_W
) (
    input  logic [P_DATA_W-1:0] vec_i,
    input  logic [P_CODE_W-1:0] elen_i,
    input  logic                dir_i,
    input  logic [P_AMT_W-1:0]  amt_i,
    output logic [P_DATA_W-1:0] res_o,
    output logic                err_o
);
    logic [P_DATA_W-1:0] stage_res [P_NUM_WIDTHS];
    shift_dir_e          dir;

    assign dir = shift_dir_e'(dir_i);

    // One candidate result per lane width, selected by the code below.
    for (genvar g = 0; g < P_NUM_WIDTHS; g++) begin : g_width
        simd_width_stage #(
            .DATA_W (P_DATA_W),
            .LANE_W (P_BASE_LANE << g),
            .AMT_W  (P_AMT_W)
        ) u_stage (
            .vec_i   (vec_i),
            .right_i (dir == SHIFT_RIGHT),
            .amt_i   (amt_i),
            .vec_o   (stage_res[g])
        );
    end

    always_comb begin
        res_o = '0;
        err_o = 1'b1;
        for (int g = 0; g < P_NUM_WIDTHS; g++) begin
            if (elen_i == P_CODE_W'(g)) begin
                res_o = stage_res[g];
                err_o = 1'b0;
            end
        end
    end
endmodule

// File: rtl/simd_lane_shift_chk.sv
module simd_lane_shift_chk #(
    parameter int P_DATA_W     = 256,
    parameter int P_BASE_LANE  = 32,
    parameter int P_NUM_WIDTHS = 3,
    parameter int P_CODE_W     = 2,
    parameter int P_AMT_W      = 8
) (
    input logic [P_DATA_W-1:0] vec_i,
    input logic [P_CODE_W-1:0] elen_i,
    input logic                dir_i,
    input logic [P_AMT_W-1:0]  amt_i,
    input logic [P_DATA_W-1:0] res_o,
    input logic                err_o
);
    logic legal;
    int   lane_w;
    assign legal  = (32'(elen_i) < P_NUM_WIDTHS);
    assign lane_w = legal ? (P_BASE_LANE << elen_i) : 0;

    always_comb begin
        assert_err_zero_R9: assert (!err_o || res_o == '0)
            else $error("err_o high with non-zero result");
        assert_identity_R8: assert (!(legal && amt_i == '0) || res_o == vec_i)
            else $error("zero shift altered operand");
        assert_clear_R7: assert (!(legal && 32'(amt_i) >= lane_w) || res_o == '0)
            else $error("oversized shift left data");
        assert_left_fill_R4: assert (!(legal && !dir_i && amt_i != '0) || !res_o[0])
            else $error("left shift did not zero-fill bit 0");
        assert_right_fill_R5: assert (!(legal && dir_i && amt_i != '0) || !res_o[P_DATA_W-1])
            else $error("right shift did not zero-fill top bit");
        assert_legal_flag_R10: assert (!legal || !err_o)
            else $error("err_o high for a legal code");
    end
endmodule

bind simd_lane_shift simd_lane_shift_chk #(
    .P_DATA_W     (P_DATA_W),
    .P_BASE_LANE  (P_BASE_LANE),
    .P_NUM_WIDTHS (P_NUM_WIDTHS),
    .P_CODE_W     (P_CODE_W),
    .P_AMT_W      (P_AMT_W)
) u_chk (.*);

// File: tb/simd_lane_shift_test.sv
module simd_lane_shift_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [255:0] vec;
    logic [1:0]   elen;
    logic         dir;
    logic [7:0]   amt;
    logic [255:0] res;
    logic         err;
    int           n_cmp = 0;
    int           n_bad = 0;
    bit           done  = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    simd_lane_shift uut (
        .vec_i  (vec),
        .elen_i (elen),
        .dir_i  (dir),
        .amt_i  (amt),
        .res_o  (res),
        .err_o  (err)
    );

    // Behavioural bit-by-bit model
    function automatic logic [255:0] model(input logic [255:0] v, input int code,
                                           input bit right, input int sh);
        logic [255:0] r = '0;
        int size;
        if (code > 2) return r;
        size = 32 * (1 << code);
        for (int b = 0; b < 256; b++) begin
            int lane_base = (b / size) * size;
            int off = b - lane_base;
            int src = right ? off + sh : off - sh;
            if (src >= 0 && src < size) r[b] = v[lane_base + src];
        end
        return r;
    endfunction

    task automatic check(input logic [255:0] v, input int code, input bit right,
                         input int sh);
        logic [255:0] exp_r;
        bit           exp_e;
        string        tag;
        int           size;
        @(posedge clk);
        #1;
        vec = v; elen = code[1:0]; dir = right; amt = sh[7:0];
        @(negedge clk);
        exp_r = model(v, code, right, sh);
        exp_e = (code == 3);
        size  = (code > 2) ? 0 : 32 * (1 << code);
        if (code == 3) tag = "R9";
        else begin
            tag = (code == 0) ? "R1" : (code == 1) ? "R2" : "R3";
            tag = {tag, right ? " R5" : " R4", " R6 R10"};
            if (sh == 0) tag = {tag, " R8"};
            else if (sh >= size) tag = {tag, " R7"};
        end
        n_cmp++;
        if (res !== exp_r || err !== exp_e) begin
            n_bad++;
            $display("FAIL %s code=%0d dir=%0d amt=%0d: res=%h err=%b expected res=%h err=%b",
                     tag, code, right, sh, res, err, exp_r, exp_e);
        end
    endtask

    initial begin
        logic [255:0] pats [4];
        vec = '0; elen = '0; dir = 1'b0; amt = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Quiet state with all-zero inputs (R10)
        @(negedge clk);
        n_cmp++;
        if (res !== '0 || err !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 idle: res=%h err=%b expected res=0 err=0", res, err);
        end
        pats[0] = '1;
        pats[1] = {64{4'hA}};
        pats[2] = {8{32'h8000_0001}};
        pats[3] = {$urandom, $urandom, $urandom, $urandom,
                   $urandom, $urandom, $urandom, $urandom};
        for (int c = 0; c < 3; c++) begin
            int size = 32 * (1 << c);
            int amts [9] = '{0, 1, 7, size/2, size-1, size, size+1, 200, 255};
            for (int d = 0; d < 2; d++)
                for (int p = 0; p < 4; p++)
                    for (int a = 0; a < 9; a++)
                        check(pats[p], c, d[0], amts[a]);
        end
        // Illegal width code (R9)
        for (int p = 0; p < 4; p++) begin
            check(pats[p], 3, 1'b0, 0);
            check(pats[p], 3, 1'b1, 5);
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule